// File: doc/BRIEF.md
# Padded 2D Strided DMA Address Generator

This block turns a two-dimensional load descriptor into a stream of address beats, one per clock cycle. Every beat carries the on-chip buffer entry it writes. Beats that fall inside the tile also carry the external memory element they read. Beats that fall in the padding margin around the tile are flagged as zero-fill and issue no external read.

A descriptor gives an external base address, an on-chip base address, a row count, a per-row element count, a row stride and four padding widths: above, below, left and right. The on-chip side walks the full padded footprint contiguously. The external side visits only the unpadded region, and consecutive rows start one stride apart.

The block takes a new descriptor on a start pulse while it is idle. It signals completion with a one-cycle done pulse.

Top module: `pad2d_addr_gen`

## Requirements
- R1: While reset is held, and after it is released with no start, `beatValid`, `busy` and `done` are all 0.
- R2: An accepted start with nonzero row and column counts produces exactly (rows+padAbove+padBelow)×(cols+padLeft+padRight) beats. They appear on consecutive cycles, beginning in the cycle after the start is sampled.
- R3: The first beat's `beatSramAddr` equals the latched on-chip base, and each following beat's is one greater, padding beats included.
- R4: Beats go in row-major order over the padded footprint. A beat at padded row r, column c has `beatZero`=1 exactly when r<padAbove, or r≥padAbove+rows, or c<padLeft, or c≥padLeft+cols.
- R5: A data beat at tile row i, column j has `beatExtAddr` = extBase + i×stride + j. The stride may differ from the column count. A zero-fill beat drives `beatExtAddr` to 0.
- R6: `done` is high for exactly one cycle, the cycle after the final beat. `beatValid` is 0 in that cycle, and `busy` returns to 0 in the cycle after it.
- R7: A start with a zero row count or a zero column count produces no beats, whatever the padding. It raises `done` for one cycle in the cycle after the start.
- R8: Descriptor inputs are sampled only when a start is accepted. A start raised while `busy` is 1 is ignored: the running sequence is unchanged and no further sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer with the descriptor presented this cycle |
| extBase | input | EXT_AW | External base element address |
| sramBase | input | SRAM_AW | On-chip base entry address |
| rowCount | input | DIM_W | Number of tile rows |
| colCount | input | DIM_W | Elements per tile row |
| rowStride | input | DIM_W | External element distance between row starts |
| padAbove | input | PAD_W | Zero rows before the tile |
| padBelow | input | PAD_W | Zero rows after the tile |
| padLeft | input | PAD_W | Zero entries before each row |
| padRight | input | PAD_W | Zero entries after each row |
| busy | output | 1 | A transfer is in progress |
| beatValid | output | 1 | A beat is presented this cycle |
| beatZero | output | 1 | The beat is zero-fill with no external read |
| beatExtAddr | output | EXT_AW | External read address (0 for zero-fill) |
| beatSramAddr | output | SRAM_AW | On-chip write address |
| done | output | 1 | One-cycle completion pulse |

## Verification
The descriptor table covers five shapes:
- a single contiguous 8-element row, which isolates the plain increment;
- an unpadded 2×9 tile with a stride of 36, which separates stride from row length;
- a 9×56 tile padded above, left and right, which fixes the 580-beat footprint count;
- two tiles with lopsided padding on every side, which catch swapped margins and off-by-one bounds.

One run scrambles the descriptor inputs and pulses start mid-sequence, to show that only latched values steer the beats. Empty descriptors with padding show that a zero dimension suppresses all beats.

// File: rtl/pad2d_pkg.sv
package pad2d_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } pad2d_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // accept descriptor, reset address registers
    logic beat;      // a beat is issued this cycle
    logic dataBeat;  // the beat reads external memory
    logic rowEnd;    // last beat of a padded row that holds tile data
  } pad2d_strobe_t;
endpackage

// File: rtl/pad2d_ctrl.sv
module pad2d_ctrl
  import pad2d_pkg::*;
#(
  parameter int DIM_W = 16,
  parameter int PAD_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIM_W-1:0] rowCount,
  input  logic [DIM_W-1:0] colCount,
  input  logic [PAD_W-1:0] padAbove,
  input  logic [PAD_W-1:0] padBelow,
  input  logic [PAD_W-1:0] padLeft,
  input  logic [PAD_W-1:0] padRight,
  output pad2d_strobe_t    strobe,
  output logic             busy,
  output logic             beatValid,
  output logic             beatZero,
  output logic             done
);
  localparam int CNT_W = DIM_W + 1;

  pad2d_state_e stateQ;
  logic [DIM_W-1:0] rowsQ, colsQ;
  logic [PAD_W-1:0] aboveQ, belowQ, leftQ, rightQ;
  logic [CNT_W-1:0] rowQ, colQ;
  logic [CNT_W-1:0] totRows, totCols, rowDataEnd, colDataEnd;
  logic accept, running, lastCol, lastRow, rowIsData, colIsData;

  assign accept  = start && (stateQ == ST_IDLE);
  assign running = (stateQ == ST_RUN);

  assign totRows    = CNT_W'(rowsQ) + CNT_W'(aboveQ) + CNT_W'(belowQ);
  assign totCols    = CNT_W'(colsQ) + CNT_W'(leftQ) + CNT_W'(rightQ);
  assign rowDataEnd = CNT_W'(aboveQ) + CNT_W'(rowsQ);
  assign colDataEnd = CNT_W'(leftQ) + CNT_W'(colsQ);

  assign lastCol   = (colQ == totCols - CNT_W'(1));
  assign lastRow   = (rowQ == totRows - CNT_W'(1));
  assign rowIsData = (rowQ >= CNT_W'(aboveQ)) && (rowQ < rowDataEnd);
  assign colIsData = (colQ >= CNT_W'(leftQ)) && (colQ < colDataEnd);

  always_comb begin
    strobe          = '0;
    strobe.load     = accept;
    strobe.beat     = running;
    strobe.dataBeat = running && rowIsData && colIsData;
    strobe.rowEnd   = running && rowIsData && lastCol;
  end

  assign busy      = (stateQ != ST_IDLE);
  assign beatValid = running;
  assign beatZero  = running && !(rowIsData && colIsData);
  assign done      = (stateQ == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      rowsQ  <= '0;
      colsQ  <= '0;
      aboveQ <= '0;
      belowQ <= '0;
      leftQ  <= '0;
      rightQ <= '0;
      rowQ   <= '0;
      colQ   <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (accept) begin
            rowsQ  <= rowCount;
            colsQ  <= colCount;
            aboveQ <= padAbove;
            belowQ <= padBelow;
            leftQ  <= padLeft;
            rightQ <= padRight;
            rowQ   <= '0;
            colQ   <= '0;
            if (rowCount == '0 || colCount == '0) stateQ <= ST_FIN;
            else                                  stateQ <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (lastCol) begin
            colQ <= '0;
            rowQ <= rowQ + CNT_W'(1);
            if (lastRow) stateQ <= ST_FIN;
          end else begin
            colQ <= colQ + CNT_W'(1);
          end
        end
        ST_FIN:  stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pad2d_dp.sv
module pad2d_dp
  import pad2d_pkg::*;
#(
  parameter int EXT_AW  = 32,
  parameter int SRAM_AW = 16,
  parameter int DIM_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  pad2d_strobe_t      strobe,
  input  logic [EXT_AW-1:0]  extBase,
  input  logic [SRAM_AW-1:0] sramBase,
  input  logic [DIM_W-1:0]   rowStride,
  output logic [EXT_AW-1:0]  beatExtAddr,
  output logic [SRAM_AW-1:0] beatSramAddr
);
  logic [EXT_AW-1:0]  rowBaseQ;
  logic [DIM_W-1:0]   strideQ;
  logic [DIM_W-1:0]   colOffQ;
  logic [SRAM_AW-1:0] sramQ;

  assign beatSramAddr = sramQ;
  assign beatExtAddr  = strobe.dataBeat ? (rowBaseQ + EXT_AW'(colOffQ)) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowBaseQ <= '0;
      strideQ  <= '0;
      colOffQ  <= '0;
      sramQ    <= '0;
    end else if (strobe.load) begin
      rowBaseQ <= extBase;
      strideQ  <= rowStride;
      colOffQ  <= '0;
      sramQ    <= sramBase;
    end else begin
      if (strobe.beat) sramQ <= sramQ + SRAM_AW'(1);
      if (strobe.rowEnd) begin
        rowBaseQ <= rowBaseQ + EXT_AW'(strideQ);
        colOffQ  <= '0;
      end else if (strobe.dataBeat) begin
        colOffQ <= colOffQ + DIM_W'(1);
      end
    end
  end
endmodule

// File: rtl/pad2d_addr_gen.sv
module pad2d_addr_gen
  import pad2d_pkg::*;
#(
  parameter int EXT_AW  = 32,
  parameter int SRAM_AW = 16,
  parameter int DIM_W   = 16,
  parameter int PAD_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [EXT_AW-1:0]  extBase,
  input  logic [SRAM_AW-1:0] sramBase,
  input  logic [DIM_W-1:0]   rowCount,
  input  logic [DIM_W-1:0]   colCount,
  input  logic [DIM_W-1:0]   rowStride,
  input  logic [PAD_W-1:0]   padAbove,
  input  logic [PAD_W-1:0]   padBelow,
  input  logic [PAD_W-1:0]   padLeft,
  input  logic [PAD_W-1:0]   padRight,
  output logic               busy,
  output logic               beatValid,
  output logic               beatZero,
  output logic [EXT_AW-1:0]  beatExtAddr,
  output logic [SRAM_AW-1:0] beatSramAddr,
  output logic               done
);
  pad2d_strobe_t strobe;

  pad2d_ctrl #(.DIM_W(DIM_W), .PAD_W(PAD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .rowCount(rowCount), .colCount(colCount),
    .padAbove(padAbove), .padBelow(padBelow),
    .padLeft(padLeft), .padRight(padRight),
    .strobe(strobe), .busy(busy), .beatValid(beatValid),
    .beatZero(beatZero), .done(done)
  );

  pad2d_dp #(.EXT_AW(EXT_AW), .SRAM_AW(SRAM_AW), .DIM_W(DIM_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .extBase(extBase), .sramBase(sramBase), .rowStride(rowStride),
    .beatExtAddr(beatExtAddr), .beatSramAddr(beatSramAddr)
  );
endmodule

// File: rtl/pad2d_addr_gen_chk.sv
module pad2d_addr_gen_chk #(
  parameter int EXT_AW  = 32,
  parameter int SRAM_AW = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               beatValid,
  input logic               beatZero,
  input logic [EXT_AW-1:0]  beatExtAddr,
  input logic [SRAM_AW-1:0] beatSramAddr,
  input logic               done
);
  AST_IDLE_NO_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !beatValid); // R2
  AST_SRAM_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && $past(beatValid)) |-> beatSramAddr == $past(beatSramAddr) + SRAM_AW'(1)); // R3
  AST_ZERO_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && beatZero) |-> beatExtAddr == '0); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!beatValid && busy)); // R6
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy); // R6
endmodule

bind pad2d_addr_gen pad2d_addr_gen_chk #(.EXT_AW(EXT_AW), .SRAM_AW(SRAM_AW)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .beatValid(beatValid),
  .beatZero(beatZero), .beatExtAddr(beatExtAddr),
  .beatSramAddr(beatSramAddr), .done(done)
);

// File: tb/pad2d_addr_gen_tb_top.sv
`timescale 1ns/1ps
module pad2d_addr_gen_tb_top;
  localparam int EXT_AW = 32, SRAM_AW = 16, DIM_W = 16, PAD_W = 4;

  typedef struct packed {
    logic [31:0] ext;
    logic [15:0] sram;
    logic [15:0] rows, cols, stride;
    logic [3:0]  pa, pb, pl, pr;
    logic [15:0] expBeats;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h0000_1000, 16'h0000, 16'd1, 16'd8,  16'd8,  4'd0, 4'd0, 4'd0, 4'd0, 16'd8},
    '{32'h0000_2000, 16'h0012, 16'd2, 16'd9,  16'd36, 4'd0, 4'd0, 4'd0, 4'd0, 16'd18},
    '{32'h0000_4000, 16'h0100, 16'd9, 16'd56, 16'd56, 4'd1, 4'd0, 4'd1, 4'd1, 16'd580},
    '{32'h0000_0050, 16'h0007, 16'd3, 16'd4,  16'd10, 4'd0, 4'd2, 4'd2, 4'd0, 16'd30},
    '{32'h0000_9000, 16'h0300, 16'd2, 16'd3,  16'd5,  4'd2, 4'd1, 4'd0, 4'd3, 16'd30}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [EXT_AW-1:0]  extBase = '0;
  logic [SRAM_AW-1:0] sramBase = '0;
  logic [DIM_W-1:0]   rowCount = '0, colCount = '0, rowStride = '0;
  logic [PAD_W-1:0]   padAbove = '0, padBelow = '0, padLeft = '0, padRight = '0;
  logic busy, beatValid, beatZero, done;
  logic [EXT_AW-1:0]  beatExtAddr;
  logic [SRAM_AW-1:0] beatSramAddr;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pad2d_addr_gen #(.EXT_AW(EXT_AW), .SRAM_AW(SRAM_AW), .DIM_W(DIM_W), .PAD_W(PAD_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .extBase(extBase), .sramBase(sramBase),
    .rowCount(rowCount), .colCount(colCount), .rowStride(rowStride),
    .padAbove(padAbove), .padBelow(padBelow), .padLeft(padLeft), .padRight(padRight),
    .busy(busy), .beatValid(beatValid), .beatZero(beatZero),
    .beatExtAddr(beatExtAddr), .beatSramAddr(beatSramAddr), .done(done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    extBase = v.ext; sramBase = v.sram;
    rowCount = v.rows; colCount = v.cols; rowStride = v.stride;
    padAbove = v.pa; padBelow = v.pb; padLeft = v.pl; padRight = v.pr;
  endtask

  task automatic scramble();
    extBase = 32'hDEAD_BEEF; sramBase = 16'h5A5A;
    rowCount = 16'd7; colCount = 16'd7; rowStride = 16'd99;
    padAbove = 4'd3; padBelow = 4'd3; padLeft = 4'd3; padRight = 4'd3;
  endtask

  // Walks one descriptor; disturb=1 scrambles inputs and pulses start mid-run (R8)
  task automatic runVec(input vec_t v, input bit disturb);
    int tr, tc, beats, idx;
    longint expExt;
    bit isData;
    tr = int'(v.rows) + int'(v.pa) + int'(v.pb);
    tc = int'(v.cols) + int'(v.pl) + int'(v.pr);
    beats = tr * tc;
    check(beats == int'(v.expBeats), "R2 footprint size", beats, v.expBeats);
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) scramble();
    idx = 0;
    for (int r = 0; r < tr; r++) begin
      for (int c = 0; c < tc; c++) begin
        isData = (r >= int'(v.pa)) && (r < int'(v.pa) + int'(v.rows)) &&
                 (c >= int'(v.pl)) && (c < int'(v.pl) + int'(v.cols));
        expExt = isData ? longint'(v.ext) + longint'(r - int'(v.pa)) * longint'(v.stride)
                          + longint'(c - int'(v.pl)) : 0;
        check(beatValid == 1'b1, "R2 beat valid", beatValid, 1);
        check(beatZero == !isData, "R4 zero flag", beatZero, !isData);
        check(beatSramAddr == SRAM_AW'(int'(v.sram) + idx), "R3 sram addr",
              beatSramAddr, SRAM_AW'(int'(v.sram) + idx));
        check(longint'(beatExtAddr) == expExt, "R5 ext addr", beatExtAddr, expExt);
        idx++;
        if (disturb && idx == 3) start = 1'b1;
        if (disturb && idx == 4) start = 1'b0;
        @(negedge clk);
      end
    end
    start = 1'b0;
    check(done == 1'b1, "R6 done after last beat", done, 1);
    check(beatValid == 1'b0, "R6 no beat with done", beatValid, 0);
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", done, 0);
    check(busy == 1'b0, "R6 busy released", busy, 0);
    if (disturb) begin
      for (int k = 0; k < 4; k++) begin
        check(beatValid == 1'b0 && busy == 1'b0, "R8 busy start ignored", beatValid, 0);
        @(negedge clk);
      end
    end
  endtask

  task automatic runEmpty(input vec_t v);
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R7 empty done", done, 1);
    check(beatValid == 1'b0, "R7 empty no beat", beatValid, 0);
    @(negedge clk);
    check(done == 1'b0 && beatValid == 1'b0, "R7 empty single done", done, 0);
    check(busy == 1'b0, "R7 empty idle", busy, 0);
  endtask

  initial begin
    vec_t e;
    repeat (3) @(negedge clk);
    check(beatValid == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 in reset",
          {beatValid, busy, done}, 0);
    rowStride = 16'd3;
    rowCount = 16'd2;
    colCount = 16'd2;
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(beatValid == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 idle after reset",
            {beatValid, busy, done}, 0);
    end
    foreach (VECS[i]) runVec(VECS[i], 1'b0);
    runVec(VECS[3], 1'b1);
    e = '{32'h100, 16'h10, 16'd4, 16'd0, 16'd4, 4'd2, 4'd2, 4'd2, 4'd2, 16'd0};
    runEmpty(e);
    e = '{32'h100, 16'h10, 16'd0, 16'd5, 16'd5, 4'd1, 4'd1, 4'd1, 4'd1, 16'd0};
    runEmpty(e);
    runVec(VECS[1], 1'b0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule